// File: doc/BRIEF.md
# Data Address Generator for Signal-Processing Loads and Stores

This unit produces the memory address for a load or store and the pointer value that the address register should hold afterwards. It supports three pointer-update rules. Plain post-increment walks through an array. Circular update keeps a pointer inside a ring of K bytes, as a FIR or IIR delay line needs. Reverse-carry update walks an FFT data set in bit-reversed index order.

The caller presents the current pointer, a signed step counted in elements, the element size, the update rule, the buffer length and an update strobe. One clock later the block presents two registered results. The effective address is always the pointer as it was presented. The new pointer is the updated value when the strobe was high, and the unchanged pointer when it was low. The caller writes the new pointer back to its register file.

Top module: `dsp_agu`

## Requirements
- R1: `ea_o` equals the `base_i` presented in the previous cycle, whatever the mode, step or strobe.
- R2: When `upd_i` was low in the previous cycle, `ptr_o` equals the `base_i` of that cycle in every mode.
- R3: In mode 0 (linear) with the strobe high, `ptr_o` is `base_i` plus the sign-extended step scaled by the element size, computed modulo 2^32.
- R4: `size_i` selects the step scale: 0 gives bytes (x1), 1 gives halfwords (x2), 2 gives words (x4), and 3 is treated as words.
- R5: In mode 1 (circular), the in-ring offset is the low `ceil(log2(len_i))` bits of the pointer. When the offset plus the scaled step reaches `len_i` or more, `len_i` is subtracted from the sum.
- R6: In mode 1, when the offset plus the scaled step is below zero, `len_i` is added to the sum.
- R7: In mode 1, pointer bits above the offset field are left unchanged. The ring base must be aligned to the power of two that holds `len_i`.
- R8: In mode 2 (bit-reversed), `len_i` is the point count N, a power of two. The log2(N)-bit index field starts at bit 0 for bytes, bit 1 for halfwords and bit 2 for words. The step is added to this field with the carry running from its top bit down toward bit 0. The carry out of bit 0 is dropped, and all bits outside the field are kept.
- R9: Mode 3 is reserved and leaves the pointer unchanged even when the strobe is high.
- R10: While `rst` is high, both outputs read zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Apply the pointer update this cycle |
| mode_i | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 reserved |
| size_i | input | 2 | Element size: 0 byte, 1 halfword, 2 or 3 word |
| base_i | input | 32 | Current pointer value |
| step_i | input | 16 | Signed step in elements |
| len_i | input | 16 | Ring length in bytes (mode 1) or point count N (mode 2) |
| ea_o | output | 32 | Registered effective address (pointer before update) |
| ptr_o | output | 32 | Registered updated pointer |

## Verification
The linear rule is tried with positive, negative and size-3 steps and with a step that carries past 2^32. These cases separate a correct scale and sign extension from a shift or truncation error. The circular rule is chained through a full lap with lengths that are not powers of two. It is also stepped backwards from offset zero and run with nonzero high address bits, which shows apart the forward wrap, the backward wrap and whether the ring base is kept. The reverse-carry rule is chained through all eight points of an 8-point word set and compared with a bit-reversed counter. It is then run at halfword size and with stray low bits below the index field, which tells a correct field position from an ordinary carry. Strobe-low and reserved-mode cases show the pointer is not touched.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AM_LIN = 2'd0,
    AM_MOD = 2'd1,
    AM_BRV = 2'd2,
    AM_RSV = 2'd3
  } agu_mode_e;

  // smallest w with 2**w >= k (0 for k <= 1)
  function automatic logic [5:0] fld_w(input logic [31:0] k);
    logic [5:0] w;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      if ((33'd1 << i) < {1'b0, k}) w = 6'(i + 1);
    end
    return w;
  endfunction

  function automatic logic [1:0] size_sh(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction

endpackage

// File: rtl/agu_scale.sv
module agu_scale #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic [SW-1:0] step_i,
  input  logic [1:0]    sh_i,
  output logic [AW-1:0] sstep_o
);
  logic [AW-1:0] ext;

  always_comb begin
    ext     = {{(AW-SW){step_i[SW-1]}}, step_i};
    sstep_o = ext << sh_i;
  end
endmodule

// File: rtl/agu_modulo.sv
module agu_modulo #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] sstep_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] nxt_o,
  output logic [AW-1:0] mask_o
);
  import agu_pkg::*;

  logic [5:0]           w;
  logic signed [AW+1:0] off, st, k, sum;

  always_comb begin
    w      = fld_w(32'(len_i));
    mask_o = ~({AW{1'b1}} << w);
    off    = {2'b00, base_i & mask_o};
    st     = {{2{sstep_i[AW-1]}}, sstep_i};
    k      = (AW+2)'(len_i);
    sum    = off + st;
    if (sum < 0)       sum = sum + k;
    else if (sum >= k) sum = sum - k;
    nxt_o  = (base_i & ~mask_o) | (sum[AW-1:0] & mask_o);
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] step_i,
  input  logic [1:0]    sh_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] nxt_o,
  output logic [AW-1:0] fmask_o
);
  import agu_pkg::*;

  logic [5:0]    w;
  logic [LW-1:0] idx, res;
  logic          c;
  logic [AW-1:0] wm;

  always_comb begin
    w   = fld_w(32'(len_i));
    idx = LW'(base_i >> sh_i);
    res = idx;
    c   = 1'b0;
    // carry runs from the top bit of the field toward bit 0
    for (int i = LW - 1; i >= 0; i--) begin
      if (i < int'(w)) begin
        res[i] = idx[i] ^ step_i[i] ^ c;
        c      = (idx[i] & step_i[i]) | (c & (idx[i] ^ step_i[i]));
      end
    end
    wm      = ~({AW{1'b1}} << w);
    fmask_o = wm << sh_i;
    nxt_o   = (base_i & ~fmask_o) | ((AW'(res) << sh_i) & fmask_o);
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] step_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] ptr_o
);
  import agu_pkg::*;

  agu_mode_e     mode;
  logic [1:0]    sh;
  logic [AW-1:0] sstep, mod_nxt, mod_mask, brv_nxt, brv_fmask, nxt;
  logic [AW-1:0] sabs;
  logic          mod_ok;

  assign mode = agu_mode_e'(mode_i);
  assign sh   = size_sh(size_i);

  agu_scale #(.AW(AW), .SW(SW)) u_scale (
    .step_i (step_i),
    .sh_i   (sh),
    .sstep_o(sstep)
  );

  agu_modulo #(.AW(AW), .LW(LW)) u_mod (
    .base_i (base_i),
    .sstep_i(sstep),
    .len_i  (len_i),
    .nxt_o  (mod_nxt),
    .mask_o (mod_mask)
  );

  agu_bitrev #(.AW(AW), .LW(LW)) u_brv (
    .base_i (base_i),
    .step_i (LW'(step_i)),
    .sh_i   (sh),
    .len_i  (len_i),
    .nxt_o  (brv_nxt),
    .fmask_o(brv_fmask)
  );

  always_comb begin
    nxt = base_i;
    if (upd_i) begin
      unique case (mode)
        AM_LIN:  nxt = base_i + sstep;
        AM_MOD:  nxt = mod_nxt;
        AM_BRV:  nxt = brv_nxt;
        default: nxt = base_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_o  <= '0;
      ptr_o <= '0;
    end else begin
      ea_o  <= base_i;
      ptr_o <= nxt;
    end
  end

  // legality of a circular update: nonempty ring, offset inside, |step| <= len
  always_comb begin
    sabs   = sstep[AW-1] ? (~sstep + 1'b1) : sstep;
    mod_ok = (len_i != '0) && ((base_i & mod_mask) < AW'(len_i)) && (sabs <= AW'(len_i));
  end

  p_rst_zero_r10: assert property (@(posedge clk)
    $past(rst) |-> (ea_o == '0 && ptr_o == '0));

  p_ea_prev_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ea_o == $past(base_i));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_i)) |-> ptr_o == $past(base_i));

  p_rsv_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == 2'd3) |-> ptr_o == $past(base_i));

  p_mod_inring_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && upd_i && mod_ok) |=> (ptr_o & $past(mod_mask)) < AW'($past(len_i)));

  p_mod_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && upd_i) |=> ((ptr_o ^ $past(base_i)) & ~$past(mod_mask)) == '0);

  p_brv_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2 && upd_i) |=> ((ptr_o ^ $past(base_i)) & ~$past(brv_fmask)) == '0);

endmodule

// File: tb/test_dsp_agu.sv
`timescale 1ns/1ps
module test_dsp_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] base_i = '0;
  logic [15:0] step_i = '0;
  logic [15:0] len_i = '0;
  logic [31:0] ea_o, ptr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dsp_agu i_dsp_agu (
    .clk(clk), .rst(rst), .upd_i(upd_i), .mode_i(mode_i), .size_i(size_i),
    .base_i(base_i), .step_i(step_i), .len_i(len_i), .ea_o(ea_o), .ptr_o(ptr_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample just after the capturing rising edge
  task automatic run(input logic [1:0] m, input logic [1:0] sz, input logic [31:0] b,
                     input logic [15:0] st, input logic [15:0] ln, input logic u);
    @(negedge clk);
    mode_i = m; size_i = sz; base_i = b; step_i = st; len_i = ln; upd_i = u;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] rev3(input logic [2:0] v);
    return {v[0], v[1], v[2]};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    run(2'd0, 2'd2, 32'h1234, 16'd1, 16'd0, 1'b1);
    check("R10 ea", ea_o, 32'h0);
    check("R10 ptr", ptr_o, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_linear();
    run(2'd0, 2'd2, 32'h100, 16'd8, 16'd0, 1'b1);
    check("R3 word +8", ptr_o, 32'h120);
    check("R1 ea linear", ea_o, 32'h100);
    run(2'd0, 2'd1, 32'h100, 16'hFFFE, 16'd0, 1'b1);
    check("R3 half -2", ptr_o, 32'hFC);
    run(2'd0, 2'd0, 32'h100, 16'd5, 16'd0, 1'b1);
    check("R4 byte +5", ptr_o, 32'h105);
    run(2'd0, 2'd3, 32'h200, 16'd1, 16'd0, 1'b1);
    check("R4 size3 as word", ptr_o, 32'h204);
    run(2'd0, 2'd2, 32'hFFFF_FFFC, 16'd1, 16'd0, 1'b1);
    check("R3 wrap 2^32", ptr_o, 32'h0);
  endtask

  task automatic t_hold();
    run(2'd0, 2'd2, 32'h500, 16'd8, 16'd0, 1'b0);
    check("R2 no strobe linear", ptr_o, 32'h500);
    check("R1 ea no strobe", ea_o, 32'h500);
    run(2'd1, 2'd2, 32'h2008, 16'd1, 16'd12, 1'b0);
    check("R2 no strobe circular", ptr_o, 32'h2008);
    run(2'd3, 2'd2, 32'h700, 16'd4, 16'd8, 1'b1);
    check("R9 reserved mode", ptr_o, 32'h700);
  endtask

  task automatic t_modulo();
    logic [31:0] p;
    p = 32'h2000;
    for (int i = 0; i < 3; i++) begin
      run(2'd1, 2'd2, p, 16'd1, 16'd12, 1'b1);
      p = ptr_o;
    end
    check("R5 lap of 12-byte ring", p, 32'h2000);
    run(2'd1, 2'd2, 32'h2004, 16'd1, 16'd12, 1'b1);
    check("R5 inside ring", ptr_o, 32'h2008);
    run(2'd1, 2'd2, 32'h2000, 16'hFFFF, 16'd12, 1'b1);
    check("R6 backward wrap", ptr_o, 32'h2008);
    run(2'd1, 2'd1, 32'h3012, 16'd3, 16'd20, 1'b1);
    check("R5 half step 3 len 20", ptr_o, 32'h3004);
    run(2'd1, 2'd2, 32'hABCD_2008, 16'd1, 16'd12, 1'b1);
    check("R7 high bits kept on wrap", ptr_o, 32'hABCD_2000);
    check("R1 ea circular", ea_o, 32'hABCD_2008);
  endtask

  task automatic t_bitrev();
    logic [31:0] p;
    p = 32'h1000;
    for (int k = 1; k <= 8; k++) begin
      run(2'd2, 2'd2, p, 16'd4, 16'd8, 1'b1);
      p = ptr_o;
      check($sformatf("R8 8-point word seq %0d", k), p,
            32'h1000 + 32'(rev3(3'(k))) * 32'd4);
    end
    run(2'd2, 2'd1, 32'hFFFF_0042, 16'd2, 16'd4, 1'b1);
    check("R8 halfword 4-point", ptr_o, 32'hFFFF_0046);
    run(2'd2, 2'd2, 32'h1003, 16'd4, 16'd8, 1'b1);
    check("R8 low bits outside field kept", ptr_o, 32'h1013);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_hold();
    t_modulo();
    t_bitrev();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule